// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside a memory ECC checker and keeps a record of the errors that the checker reports. Each report is either correctable (a single-bit error) or uncorrectable (a multi-bit error). The block logs the failing address at 4 KiB granularity, the 8-bit syndrome and the channel of one report. It keeps a status word with one sticky flag per error class. Software clears these flags by writing 1 to them.

An uncorrectable error outranks a correctable one. If a correctable error's details are held, a newly arriving uncorrectable error replaces them, and both flags stay set. Software can therefore tell that the correctable details were lost. A command register selects which error classes produce a one-cycle system-error pulse.

Reports arrive on a valid/ready stream. Ready is held high at all times, so the checker is never back-pressured, and every cycle with valid high carries one report. The register port is a plain single-cycle write strobe with an asynchronous read mux.

Top module: `eccerr_logger`

## Requirements
- R1: After reset, every register reads zero, the system-error pulse is low and the event stream ready is high.
- R2: A correctable report with no flag pending sets status bit 0 on the next cycle. The same cycle it captures the report: address bits 31:12 (the error address register reads bits 11:0 as zero), the 8-bit syndrome, and the channel in bit 0 of the channel register (bits 7:1 read zero).
- R3: An uncorrectable report with no uncorrectable flag pending sets status bit 7 on the next cycle and captures the address, syndrome and channel.
- R4: An uncorrectable report that arrives while only the correctable flag is set overwrites the captured address, syndrome and channel. Status then reads 0x0081.
- R5: A correctable report that arrives while the correctable flag is set leaves the captured details unchanged.
- R6: While the uncorrectable flag is set, any further report of either class leaves the captured details unchanged.
- R7: A register write to the status word (word address 0) clears bit 0 or bit 7 where the written bit is 1. A written 0 leaves the flag unchanged. The capture registers are untouched. Status bits 15:10, 6 and the other reserved bits always read zero.
- R8: If a clear and a new report of the same class fall in the same cycle, the flag stays set. The report is treated as arriving with that flag already cleared, so it is captured when no other flag remains pending.
- R9: Only bits 7 (correctable enable) and 8 (uncorrectable enable) of the command register (word address 1) can be written. All its other bits read zero.
- R10: The system-error output is high for exactly one cycle: the cycle in which a status flag first reads 1, provided that the flag's enable was set when the report arrived. It does not pulse for a report that finds its flag already set.
- R11: Event stream ready is always high, so a report is accepted in every cycle that has valid high.
- R12: Once every flag has been cleared, the next correctable report is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error report valid |
| evt_ready | output | 1 | Report accepted (always 1) |
| evt_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| evt_addr | input | 32 | Failing byte address |
| evt_syn | input | 8 | ECC syndrome |
| evt_chan | input | 1 | Channel of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0 status, 1 command, 2 address, 3 syndrome, 4 channel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| serr | output | 1 | One-cycle system-error pulse |

## Verification
Every result of a report or a register write is registered once. The status flags, the captured details, the command bits and the system-error pulse are all visible one clock after the edge that accepts the stimulus. Read data follows the address with no clock. The bench drives inputs on the falling edge and lets one rising edge pass. It samples at the next falling edge, where the pulse must be high, and one cycle later, where it must be low again. Each capture case reads all three detail registers, because a wrong load would show up in any one of them.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  localparam int REG_AW  = 3;
  localparam int NCLS    = 2;   // class 0 = correctable, class 1 = uncorrectable
  localparam int CLS_CE  = 0;
  localparam int CLS_UE  = 1;
  localparam int STAT_CE_BIT = 0;
  localparam int STAT_UE_BIT = 7;
  localparam int CMD_CE_BIT  = 7;
  localparam int CMD_UE_BIT  = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 3'd0,
    RA_CMD    = 3'd1,
    RA_ADDR   = 3'd2,
    RA_SYN    = 3'd3,
    RA_CHAN   = 3'd4
  } reg_addr_e;

  function automatic int stat_pos(input int cls);
    return (cls == CLS_CE) ? STAT_CE_BIT : STAT_UE_BIT;
  endfunction

  function automatic int cmd_pos(input int cls);
    return (cls == CLS_CE) ? CMD_CE_BIT : CMD_UE_BIT;
  endfunction
endpackage

// File: rtl/ecclog_status.sv
module ecclog_status #(
  parameter int NCLS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] ev,
  input  logic [NCLS-1:0] clr,
  output logic [NCLS-1:0] flag_q,
  output logic [NCLS-1:0] rise
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic nxt;
    // a new event of the class wins over a same-cycle clear
    assign nxt     = (flag_q[c] & ~clr[c]) | ev[c];
    assign rise[c] = nxt & ~flag_q[c];
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[c] <= 1'b0;
      else        flag_q[c] <= nxt;
    end
  end
endmodule

// File: rtl/ecclog_capture.sv
module ecclog_capture #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-1:BLK_LSB]   in_blk,
  input  logic [SYN_W-1:0]          in_syn,
  input  logic                      in_chan,
  output logic [ADDR_W-1:BLK_LSB]   blk_q,
  output logic [SYN_W-1:0]          syn_q,
  output logic                      chan_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (load) begin
      blk_q  <= in_blk;
      syn_q  <= in_syn;
      chan_q <= in_chan;
    end
  end
endmodule

// File: rtl/ecclog_regs.sv
module ecclog_regs
  import ecclog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [REG_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NCLS-1:0]         flag_q,
  input  logic [NCLS-1:0]         rise,
  input  logic [ADDR_W-1:BLK_LSB] blk_q,
  input  logic [SYN_W-1:0]        syn_q,
  input  logic                    chan_q,
  output logic [NCLS-1:0]         clr,
  output logic [DATA_W-1:0]       rdata,
  output logic                    serr
);
  logic [NCLS-1:0] en_q;
  logic            wr_status, wr_cmd;
  logic            serr_q;

  assign wr_status = wr && (reg_addr_e'(addr) == RA_STATUS);
  assign wr_cmd    = wr && (reg_addr_e'(addr) == RA_CMD);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign clr[c] = wr_status & wdata[stat_pos(c)];
    always_ff @(posedge clk) begin
      if (!rst_n)      en_q[c] <= 1'b0;
      else if (wr_cmd) en_q[c] <= wdata[cmd_pos(c)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= |(rise & en_q);
  end
  assign serr = serr_q;

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      RA_STATUS: begin
        for (int c = 0; c < NCLS; c++) rdata[stat_pos(c)] = flag_q[c];
      end
      RA_CMD: begin
        for (int c = 0; c < NCLS; c++) rdata[cmd_pos(c)] = en_q[c];
      end
      RA_ADDR:  rdata[ADDR_W-1:BLK_LSB] = blk_q;
      RA_SYN:   rdata[SYN_W-1:0]        = syn_q;
      RA_CHAN:  rdata[0]                = chan_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/eccerr_logger.sv
module eccerr_logger
  import ecclog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  output logic                evt_ready,
  input  logic                evt_ue,
  input  logic [ADDR_W-1:0]   evt_addr,
  input  logic [SYN_W-1:0]    evt_syn,
  input  logic                evt_chan,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                serr
);
  logic [NCLS-1:0]         ev, clr, flag_q, rise, pend;
  logic                    cap_load;
  logic [ADDR_W-1:BLK_LSB] cap_blk;
  logic [SYN_W-1:0]        cap_syn;
  logic                    cap_chan;

  assign evt_ready  = 1'b1;
  assign ev[CLS_CE] = evt_valid & evt_ready & ~evt_ue;
  assign ev[CLS_UE] = evt_valid & evt_ready &  evt_ue;

  // pending flags as they stand after this cycle's clear write
  assign pend     = flag_q & ~clr;
  assign cap_load = (ev[CLS_UE] & ~pend[CLS_UE]) | (ev[CLS_CE] & ~(|pend));

  ecclog_status #(.NCLS(NCLS)) u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr),
    .flag_q(flag_q), .rise(rise)
  );

  ecclog_capture #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load),
    .in_blk(evt_addr[ADDR_W-1:BLK_LSB]), .in_syn(evt_syn), .in_chan(evt_chan),
    .blk_q(cap_blk), .syn_q(cap_syn), .chan_q(cap_chan)
  );

  ecclog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag_q(flag_q), .rise(rise), .blk_q(cap_blk), .syn_q(cap_syn), .chan_q(cap_chan),
    .clr(clr), .rdata(reg_rdata), .serr(serr)
  );
endmodule

// File: rtl/ecclog_checker.sv
module ecclog_checker #(
  parameter int SYN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_ue,
  input logic [SYN_W-1:0] evt_syn,
  input logic [1:0]       flag_q,
  input logic [1:0]       clr,
  input logic [SYN_W-1:0] cap_syn,
  input logic             serr
);
  p_ce_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ue) |=> flag_q[0]);

  p_ue_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ue) |=> flag_q[1]);

  p_ue_overwrites_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ue && !flag_q[1]) |=> (cap_syn == $past(evt_syn)));

  p_ce_keeps_details_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !clr[0] && !(evt_valid && evt_ue)) |=> $stable(cap_syn));

  p_ue_keeps_details_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !clr[1]) |=> $stable(cap_syn));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !(evt_valid && !evt_ue)) |=> !flag_q[0]);

  p_serr_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    serr |-> ($rose(flag_q[0]) || $rose(flag_q[1])));
endmodule

bind eccerr_logger ecclog_checker #(.SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ue(evt_ue),
  .evt_syn(evt_syn), .flag_q(flag_q), .clr(clr), .cap_syn(cap_syn), .serr(serr)
);

// File: tb/eccerr_logger_tb_top.sv
`timescale 1ns/1ps
module eccerr_logger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_ue = 1'b0, evt_chan = 1'b0;
  logic        evt_ready;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr;
  int          total = 0, bad = 0;
  bit          done = 0;

  localparam logic [2:0] A_ST = 3'd0, A_CMD = 3'd1, A_ADR = 3'd2, A_SYN = 3'd3, A_CH = 3'd4;

  always #5 clk = ~clk;

  eccerr_logger dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_ue(evt_ue), .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serr(serr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic ue, input logic [31:0] ad, input logic [7:0] sy, input logic ch);
    evt_valid = 1'b1; evt_ue = ue; evt_addr = ad; evt_syn = sy; evt_chan = ch;
    step();
    evt_valid = 1'b0;
  endtask

  task automatic details(input string tag, input logic [31:0] ad, input logic [7:0] sy, input logic ch);
    rd(A_ADR, tag, ad);
    rd(A_SYN, tag, {24'h0, sy});
    rd(A_CH,  tag, {31'h0, ch});
  endtask

  task automatic t_reset();
    rd(A_ST, "R1 status", 32'h0);
    rd(A_CMD, "R1 cmd", 32'h0);
    details("R1 details", 32'h0, 8'h0, 1'b0);
    chk("R1 serr", {31'h0, serr}, 32'h0);
    chk("R11 ready", {31'h0, evt_ready}, 32'h1);
  endtask

  task automatic t_cmd();
    wr(A_CMD, 32'hFFFF_FFFF);
    rd(A_CMD, "R9 cmd reserved", 32'h0000_0180);
    wr(A_CMD, 32'h0000_0100);
    rd(A_CMD, "R9 cmd ue only", 32'h0000_0100);
    wr(A_CMD, 32'h0000_0180);
  endtask

  task automatic t_ce_basic();
    send(1'b0, 32'h1234_5ABC, 8'h5A, 1'b1);
    chk("R10 serr on CE", {31'h0, serr}, 32'h1);
    rd(A_ST, "R2 status", 32'h0000_0001);
    details("R2 capture", 32'h1234_5000, 8'h5A, 1'b1);
    step();
    chk("R10 serr one cycle", {31'h0, serr}, 32'h0);
  endtask

  task automatic t_ce_hold();
    send(1'b0, 32'hAAAA_A000, 8'h11, 1'b0);
    chk("R10 no serr when set", {31'h0, serr}, 32'h0);
    details("R5 hold", 32'h1234_5000, 8'h5A, 1'b1);
  endtask

  task automatic t_ue_over();
    send(1'b1, 32'h0BAD_0FFF, 8'hC3, 1'b0);
    chk("R10 serr on UE", {31'h0, serr}, 32'h1);
    rd(A_ST, "R4 both flags", 32'h0000_0081);
    details("R4 overwrite", 32'h0BAD_0000, 8'hC3, 1'b0);
  endtask

  task automatic t_ue_hold();
    send(1'b1, 32'h7777_7000, 8'h22, 1'b1);
    details("R6 ue hold", 32'h0BAD_0000, 8'hC3, 1'b0);
    send(1'b0, 32'h6666_6000, 8'h33, 1'b1);
    details("R6 ce under ue", 32'h0BAD_0000, 8'hC3, 1'b0);
  endtask

  task automatic t_w1c();
    wr(A_ST, 32'hFFFF_FF7E);
    rd(A_ST, "R7 zeros keep", 32'h0000_0081);
    wr(A_ST, 32'h0000_0001);
    rd(A_ST, "R7 clear CE", 32'h0000_0080);
    wr(A_ST, 32'h0000_0080);
    rd(A_ST, "R7 clear UE", 32'h0000_0000);
    rd(A_ADR, "R7 details kept", 32'h0BAD_0000);
  endtask

  task automatic t_recapture();
    send(1'b0, 32'h0000_1FFF, 8'h01, 1'b1);
    rd(A_ST, "R12 status", 32'h0000_0001);
    details("R12 recapture", 32'h0000_1000, 8'h01, 1'b1);
  endtask

  task automatic t_same_cycle();
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h1;
    evt_valid = 1'b1; evt_ue = 1'b0; evt_addr = 32'h0002_2000; evt_syn = 8'h44; evt_chan = 1'b0;
    step();
    reg_wr = 1'b0; evt_valid = 1'b0;
    rd(A_ST, "R8 flag stays", 32'h0000_0001);
    details("R8 captured", 32'h0002_2000, 8'h44, 1'b0);
    chk("R10 no serr w/o rise", {31'h0, serr}, 32'h0);
    wr(A_ST, 32'h81);
    rd(A_ST, "R7 all clear", 32'h0);
  endtask

  task automatic t_enables();
    wr(A_CMD, 32'h0);
    send(1'b0, 32'h0003_3000, 8'h55, 1'b1);
    chk("R10 CE disabled", {31'h0, serr}, 32'h0);
    rd(A_ST, "R2 flag w/o enable", 32'h1);
    wr(A_CMD, 32'h100);
    send(1'b1, 32'h0004_4000, 8'h66, 1'b0);
    chk("R10 UE enabled", {31'h0, serr}, 32'h1);
    rd(A_ST, "R3 status", 32'h81);
    details("R3 capture", 32'h0004_4000, 8'h66, 1'b0);
    chk("R11 ready busy", {31'h0, evt_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_ce_basic();
    t_ce_hold();
    t_ue_over();
    t_ue_hold();
    t_w1c();
    t_recapture();
    t_same_cycle();
    t_enables();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule